// File: doc/BRIEF.md
# Fuse Array Read Controller

This block gives software indirect access to a small one-time-programmable fuse array of 16-bit words. It sits behind a single-cycle 32-bit register port. To fetch a word, software sets the unit-enable bit and loads a block index. It then writes the read-start bit and polls the status register until the read-done flag appears. Next it reads the data register, writes the clear-done bit, and finally drops the unit-enable bit.

The fuse contents are modelled as a read-only array whose words are computed from a seed parameter. The read sequencer holds the controller out of standby for a configurable number of clock cycles and then loads the data register. Only a read that starts while the controller is enabled and in standby is accepted. Fuse programming is not modelled; its start bit, busy flag and protect flag are inert.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the unit-enable bit, block index, data register and done flag are all 0, read-busy is 0 and standby is 1. Status therefore reads 0x4.
- R2: The block index lives at offset 0x0C and keeps only bits [4:0]. The unit-enable bit is bit 6 of offset 0x40. All other bits of both registers read back as 0.
- R3: The mode register is at offset 0x10. Bit 1 starts a read and bit 2 clears the done flag. Bit 0 (program start) has no effect on status or data. The mode register always reads back 0.
- R4: The status register is at offset 0x14. Bit 1 is read-busy, bit 2 is standby, bit 4 is read-done, and bits 0 and 3 always read 0.
- R5: A read start written while unit-enable is 0, or while a read is in progress, is ignored. Status, data and the current read's timing are left unchanged.
- R6: An accepted start made in edge k sets read-busy and clears standby for exactly LAT cycles. Edge k+LAT clears read-busy, restores standby and sets read-done.
- R7: The data register at offset 0x04 is the zero-extended word of the index held when the start was accepted. Index writes during the read have no effect on it. It holds its value until the next read completes.
- R8: Read-done stays set until a clear-done write, however many cycles pass.
- R9: The fuse word at block i equals (SEED + i*0x0425) mod 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |

## Verification
The assertions assume that a write lasts exactly one cycle, with address and data steady around the sampling edge. They also assume LAT is at least 1, so an accepted start always produces a busy window. The bench drives every write for a single cycle from the falling edge and reads status between edges. It issues extra starts and index writes only in the phases whose outcome the requirements fix, such as disabled, mid-read and after completion.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int RW = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RDATA  = 8'h04;
  localparam logic [7:0] OFS_WDATA  = 8'h08;
  localparam logic [7:0] OFS_INDEX  = 8'h0C;
  localparam logic [7:0] OFS_MODE   = 8'h10;
  localparam logic [7:0] OFS_STATUS = 8'h14;
  localparam logic [7:0] OFS_UNIT   = 8'h40;

  localparam int MODE_PGM_BIT = 0;
  localparam int MODE_RD_BIT  = 1;
  localparam int MODE_CLR_BIT = 2;

  localparam int ST_PGM_BUSY = 0;
  localparam int ST_RD_BUSY  = 1;
  localparam int ST_STANDBY  = 2;
  localparam int ST_PROT     = 3;
  localparam int ST_DONE     = 4;

  localparam int UNIT_EN_BIT = 6;
endpackage

// File: rtl/fuse_rom.sv
module fuse_rom #(
  parameter int          NBLK = 32,
  parameter int          DW   = 16,
  parameter logic [15:0] SEED = 16'hA5C3,
  localparam int         IW   = $clog2(NBLK)
) (
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] words [NBLK];

  for (genvar i = 0; i < NBLK; i++) begin : g_word
    assign words[i] = DW'(SEED) + DW'(i * 32'h0425);
  end

  assign word_o = words[idx_i];
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int NBLK = 32,
  parameter int DW   = 16,
  parameter int LAT  = 6,
  localparam int IW  = $clog2(NBLK),
  localparam int CW  = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] rom_word_i,
  output logic [IW-1:0] rom_idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic          accept, finish;

  assign accept = start_i && en_i && !busy_q;
  assign finish = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
      idx_q  <= idx_i;            // snapshot, later index writes do not matter
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (finish) data_q <= rom_word_i;
      if (finish)      done_q <= 1'b1;   // completion beats a same-cycle clear
      else if (clr_i)  done_q <= 1'b0;
    end
  end

  assign rom_idx_o = idx_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign data_o    = data_q;

  // checker: length of each busy window
  logic [CW:0] chk_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chk_len <= '0;
    else if (busy_q) chk_len <= chk_len + 1'b1;
    else             chk_len <= '0;
  end

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (chk_len == (CW+1)'(LAT)));

  p_done_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> done_q);

  p_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(data_q));
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 5,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  output logic          en_o,
  output logic [IW-1:0] idx_o,
  output logic          start_o,
  output logic          clr_o,
  output logic [RW-1:0] rdata_o
);
  logic          en_q;
  logic [IW-1:0] idx_q;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == AW'(OFS_UNIT))  en_q  <= wdata_i[UNIT_EN_BIT];
      if (addr_i == AW'(OFS_INDEX)) idx_q <= wdata_i[IW-1:0];
    end
  end

  // mode bits are pulses, nothing is stored
  assign start_o = wr_en_i && (addr_i == AW'(OFS_MODE)) && wdata_i[MODE_RD_BIT];
  assign clr_o   = wr_en_i && (addr_i == AW'(OFS_MODE)) && wdata_i[MODE_CLR_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_RDATA):  rdata_o[DW-1:0] = data_i;
      AW'(OFS_INDEX):  rdata_o[IW-1:0] = idx_q;
      AW'(OFS_UNIT):   rdata_o[UNIT_EN_BIT] = en_q;
      AW'(OFS_STATUS): begin
        rdata_o[ST_RD_BUSY] = busy_i;
        rdata_o[ST_STANDBY] = !busy_i;
        rdata_o[ST_DONE]    = done_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign idx_o = idx_q;

  p_mode_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_MODE)) |-> (rdata_o == '0));
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int          AW   = 8,
  parameter int          NBLK = 32,
  parameter int          DW   = 16,
  parameter int          LAT  = 6,
  parameter logic [15:0] SEED = 16'hA5C3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  localparam int IW = $clog2(NBLK);

  logic          en, start, clr, busy, done;
  logic [IW-1:0] idx, rom_idx;
  logic [DW-1:0] rom_word, data;

  fuse_rd_regs #(.AW(AW), .IW(IW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .busy_i(busy), .done_i(done), .data_i(data),
    .en_o(en), .idx_o(idx), .start_o(start), .clr_o(clr), .rdata_o
  );

  fuse_rd_seq #(.NBLK(NBLK), .DW(DW), .LAT(LAT)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .clr_i(clr), .en_i(en),
    .idx_i(idx), .rom_word_i(rom_word), .rom_idx_o(rom_idx),
    .busy_o(busy), .done_o(done), .data_o(data)
  );

  fuse_rom #(.NBLK(NBLK), .DW(DW), .SEED(SEED)) u_rom (
    .idx_i(rom_idx), .word_o(rom_word)
  );

  p_idle_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(OFS_MODE) && wdata_i[MODE_RD_BIT] &&
     !wdata_i[MODE_CLR_BIT] && !en && !busy) |=> (!busy && $stable(done)));
endmodule

// File: tb/sim_fuse_rd_ctrl.sv
module sim_fuse_rd_ctrl;
  localparam int          LAT  = 5;
  localparam logic [15:0] SEED = 16'h3C5A;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fuse_rd_ctrl #(.LAT(LAT), .SEED(SEED)) u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] exp_word(int i);
    logic [15:0] w;
    w = SEED + 16'(i * 16'h0425);
    return {16'h0, w};
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_rd(string req, string what, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic t_reset();
    chk_rd("R1", "status", 8'h14, 32'h4);
    chk_rd("R1", "data", 8'h04, 32'h0);
    chk_rd("R1", "index", 8'h0C, 32'h0);
    chk_rd("R1", "enable", 8'h40, 32'h0);
  endtask

  task automatic t_regs();
    wr(8'h0C, 32'hFFFF_FFE7);
    chk_rd("R2", "index masked", 8'h0C, 32'h7);
    wr(8'h40, 32'hFFFF_FFFF);
    chk_rd("R2", "enable only bit6", 8'h40, 32'h40);
    wr(8'h40, 32'h0);
    chk_rd("R2", "enable cleared", 8'h40, 32'h0);
    wr(8'h10, 32'h0000_0001);
    chk_rd("R3", "mode reads 0", 8'h10, 32'h0);
    chk_rd("R3", "program start inert", 8'h14, 32'h4);
    chk_rd("R4", "pgm busy and protect 0", 8'h14, 32'h4);
  endtask

  task automatic t_disabled_start();
    wr(8'h40, 32'h0);
    wr(8'h0C, 32'd3);
    wr(8'h10, 32'h2);
    chk_rd("R5", "disabled start status", 8'h14, 32'h4);
    repeat (LAT + 2) @(negedge clk);
    chk_rd("R5", "disabled start later", 8'h14, 32'h4);
    chk_rd("R5", "disabled start data", 8'h04, 32'h0);
  endtask

  task automatic t_read(int i);
    wr(8'h40, 32'h40);
    wr(8'h0C, 32'(i));
    wr(8'h10, 32'h2);
    chk_rd("R6", "busy after start", 8'h14, 32'h2);
    repeat (LAT - 1) @(negedge clk);
    chk_rd("R6", "busy last cycle", 8'h14, 32'h2);
    @(negedge clk);
    chk_rd("R6", "done and standby", 8'h14, 32'h14);
    chk_rd("R9", $sformatf("word %0d", i), 8'h04, exp_word(i));
    repeat (20) @(negedge clk);
    chk_rd("R8", "done sticky", 8'h14, 32'h14);
    wr(8'h10, 32'h4);
    chk_rd("R8", "done cleared", 8'h14, 32'h4);
    chk_rd("R7", "data after clear", 8'h04, exp_word(i));
    wr(8'h40, 32'h0);
  endtask

  task automatic t_busy_restart();
    wr(8'h40, 32'h40);
    wr(8'h0C, 32'd9);
    wr(8'h10, 32'h2);
    wr(8'h0C, 32'd20);
    wr(8'h10, 32'h2);
    chk_rd("R5", "restart ignored busy", 8'h14, 32'h2);
    repeat (LAT - 3) @(negedge clk);
    chk_rd("R5", "first read timing kept", 8'h14, 32'h14);
    chk_rd("R7", "index snapshot", 8'h04, exp_word(9));
    wr(8'h10, 32'h4);
    repeat (LAT + 3) @(negedge clk);
    chk_rd("R5", "no deferred read", 8'h14, 32'h4);
    chk_rd("R7", "data holds", 8'h04, exp_word(9));
    wr(8'h40, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_disabled_start();
    t_read(0);
    t_read(31);
    t_read(17);
    t_busy_restart();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule